// File: doc/BRIEF.md
# CAN Transceiver Mode Controller

This block is the digital control unit of a high-speed CAN transceiver. It decides, once per clock, which of four operating modes the transceiver is in: Unpowered, Standby, Silent (receive only) or Normal (transmit and receive). It takes the standby and silent control pins, the transmit data pin, two supply undervoltage flags, the output of the high-speed bus comparator and a readback of the receive data pin. From these it drives the mode, a permit for the bus driver stage and a select for the source of the receive data pin.

The block also watches for a receive pin that is stuck recessive. In Silent or Normal, the comparator may report a dominant bus for a run of clocks while the receive pin still reads high. When that happens, an error is latched that keeps the transceiver out of Normal. This stops a node whose controller cannot see the bus from transmitting blindly. The four pin inputs pass through reset-to-high synchronisers, which model the pull-ups on the pins. The debounce length is a parameter given in clock cycles. A parameter also selects the variant that has no silent-control pin.

Top module: `can_xcvr_mode_ctrl`

## Requirements
- R1: After reset, mode_o is Unpowered, drv_en_o is 0 and rxd_sel_o selects forced recessive, and the clamp error is clear.
- R2: mode_o encodes Unpowered as 2'b00, Standby as 2'b01, Silent as 2'b10 and Normal as 2'b11. rxd_sel_o is 2'b00 (force high) in Unpowered, 2'b01 (wake path) in Standby and 2'b10 (comparator) in Silent and Normal.
- R3: While vcc_uv_i or vio_uv_i is high, the mode becomes Unpowered on the next clock whatever the pins show, so the standby pin is ignored.
- R4: Once both supplies are good, a synchronised standby pin high selects Standby from any mode.
- R5: When the standby pin is low and the machine is not in Normal, it enters Normal only when the silent pin is high, the transmit pin is high and the clamp error is clear; otherwise it enters Silent.
- R6: In Normal with the standby pin low, the mode stays Normal whatever the transmit pin does, and it goes to Silent when the silent pin goes low.
- R7: Normal is never entered from another mode while the synchronised transmit pin is low.
- R8: In Silent or Normal, if hsc_dom_i is high and the synchronised RXD readback is high on DEBOUNCE_CYC consecutive clocks, the clamp error sets and Normal falls back to Silent. A shorter run has no effect.
- R9: The clamp error clears when the synchronised RXD readback is low, or when the mode is Standby or Unpowered. After that, Normal may be entered again.
- R10: drv_en_o is high only in Normal.
- R11: With HAS_SILENT_PIN = 0, the silent pin is ignored and treated as high.
- R12: A pin change reaches mode_o on the third rising clock after it is applied (two synchroniser stages plus the mode register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_pin_i | input | 1 | Standby control pin (1 = standby) |
| sil_n_pin_i | input | 1 | Silent control pin, active low |
| txd_pin_i | input | 1 | Transmit data pin (0 = dominant) |
| vcc_uv_i | input | 1 | Main supply undervoltage flag |
| vio_uv_i | input | 1 | I/O supply undervoltage flag |
| hsc_dom_i | input | 1 | High-speed comparator reports dominant bus |
| rxd_rb_i | input | 1 | Readback of the receive data pin |
| mode_o | output | 2 | Current operating mode |
| drv_en_o | output | 1 | Bus driver permit |
| rxd_sel_o | output | 2 | Source select for the receive data pin |

## Verification
Every combination of the standby, silent and transmit pins is applied from three starting points: Standby, Normal and Unpowered with a supply fault that then recovers. This separates the rule for entering Normal from the rule for staying in it, and shows that the pins are ignored during undervoltage. Clamp runs one clock shorter than the debounce length and well beyond it tell a correct count from an off-by-one. The error is then released in two ways, by a low RXD readback and by a Standby visit, to show that each one alone clears it. A second instance without the silent pin is driven with the silent pin low to show that the pin is ignored there.

// File: rtl/can_xcvr_mode_ctrl.sv
module can_xcvr_mode_ctrl #(
  parameter int SYNC_STAGES    = 2,
  parameter int DEBOUNCE_CYC   = 9,
  parameter bit HAS_SILENT_PIN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_pin_i,
  input  logic       sil_n_pin_i,
  input  logic       txd_pin_i,
  input  logic       vcc_uv_i,
  input  logic       vio_uv_i,
  input  logic       hsc_dom_i,
  input  logic       rxd_rb_i,
  output logic [1:0] mode_o,
  output logic       drv_en_o,
  output logic [1:0] rxd_sel_o
);
  localparam int LAST = SYNC_STAGES - 1;
  localparam int CW   = $clog2(DEBOUNCE_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(DEBOUNCE_CYC - 1);

  typedef enum logic [1:0] {
    M_UNPOW = 2'd0,
    M_STBY  = 2'd1,
    M_SIL   = 2'd2,
    M_NORM  = 2'd3
  } mode_t;

  logic [3:0] sync_q [SYNC_STAGES];
  logic stby_s, nsil_s, txd_s, rxd_s, uv;
  mode_t mode_q, mode_d;
  logic err_q;
  logic [CW-1:0] cnt_q;
  logic clamp_cond, rx_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 4'hF;
    end else begin
      sync_q[0] <= {rxd_rb_i, txd_pin_i, sil_n_pin_i, stby_pin_i};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign stby_s = sync_q[LAST][0];
  assign txd_s  = sync_q[LAST][2];
  assign rxd_s  = sync_q[LAST][3];
  assign uv     = vcc_uv_i | vio_uv_i;

  generate
    if (HAS_SILENT_PIN) begin : g_sil_pin
      assign nsil_s = sync_q[LAST][1];
    end else begin : g_no_sil_pin
      assign nsil_s = 1'b1;
    end
  endgenerate

  always_comb begin
    mode_d = mode_q;
    if (uv)
      mode_d = M_UNPOW;
    else if (stby_s)
      mode_d = M_STBY;
    else if (mode_q == M_NORM)
      mode_d = (!nsil_s || err_q) ? M_SIL : M_NORM;
    else
      mode_d = (nsil_s && txd_s && !err_q) ? M_NORM : M_SIL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_UNPOW;
    else        mode_q <= mode_d;
  end

  assign rx_active  = (mode_q == M_SIL) || (mode_q == M_NORM);
  assign clamp_cond = rx_active && hsc_dom_i && rxd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= (clamp_cond && cnt_q != CNT_TOP) ? cnt_q + 1'b1 : '0;
      if (!rx_active || !rxd_s)
        err_q <= 1'b0;
      else if (clamp_cond && cnt_q == CNT_TOP)
        err_q <= 1'b1;
    end
  end

  assign mode_o    = mode_q;
  assign drv_en_o  = (mode_q == M_NORM);
  assign rxd_sel_o = (mode_q == M_UNPOW) ? 2'b00 :
                     (mode_q == M_STBY)  ? 2'b01 : 2'b10;

  a_r3_uv_forces_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    uv |=> mode_q == M_UNPOW);
  a_r4_stby_selects_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv && stby_s) |=> mode_q == M_STBY);
  a_r7_no_entry_txd_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_NORM && !txd_s) |=> mode_q != M_NORM);
  a_r8_err_needs_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> ($past(hsc_dom_i) && $past(rxd_s) && $past(rx_active)));
  a_r8_err_leaves_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && mode_q == M_NORM && !uv && !stby_s) |=> mode_q == M_SIL);
  a_r9_err_clear_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_STBY || mode_q == M_UNPOW) |=> !err_q);
  a_r9_err_clear_rxd_low: assert property (@(posedge clk) disable iff (!rst_n)
    !rxd_s |=> !err_q);
endmodule

// File: tb/can_xcvr_mode_ctrl_tb_top.sv
module can_xcvr_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby = 1'b1, nsil = 1'b1, txd = 1'b1, vcc_uv = 1'b0, vio_uv = 1'b0;
  logic hsc = 1'b0, rxd = 1'b1;
  logic [1:0] mode, rsel, mode2, rsel2;
  logic drv, drv2;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_xcvr_mode_ctrl #(.DEBOUNCE_CYC(DEB)) dut_i (
    .clk(clk), .rst_n(rst_n), .stby_pin_i(stby), .sil_n_pin_i(nsil), .txd_pin_i(txd),
    .vcc_uv_i(vcc_uv), .vio_uv_i(vio_uv), .hsc_dom_i(hsc), .rxd_rb_i(rxd),
    .mode_o(mode), .drv_en_o(drv), .rxd_sel_o(rsel));

  can_xcvr_mode_ctrl #(.DEBOUNCE_CYC(DEB), .HAS_SILENT_PIN(1'b0)) dut_nosil_i (
    .clk(clk), .rst_n(rst_n), .stby_pin_i(stby), .sil_n_pin_i(nsil), .txd_pin_i(txd),
    .vcc_uv_i(vcc_uv), .vio_uv_i(vio_uv), .hsc_dom_i(hsc), .rxd_rb_i(rxd),
    .mode_o(mode2), .drv_en_o(drv2), .rxd_sel_o(rsel2));

  localparam logic [1:0] UNP = 2'd0, STB = 2'd1, SIL = 2'd2, NRM = 2'd3;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input logic s, input logic ns, input logic t);
    stby = s; nsil = ns; txd = t;
  endtask

  function automatic logic [1:0] sel_of(input logic [1:0] m);
    return (m == UNP) ? 2'b00 : (m == STB) ? 2'b01 : 2'b10;
  endfunction

  task automatic chk(input logic [1:0] am, input logic ad, input logic [1:0] as_,
                     input logic [1:0] exp, input string req);
    checks++;
    if (am !== exp || ad !== (exp == NRM) || as_ !== sel_of(exp)) begin
      failures++;
      $display("FAIL %s: mode=%0d drv=%0d sel=%0d expected mode=%0d drv=%0d sel=%0d",
               req, am, ad, as_, exp, (exp == NRM), sel_of(exp));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(2);
    chk(mode, drv, rsel, UNP, "R1 reset state");
    rst_n = 1'b1;
    tick(1);
    chk(mode, drv, rsel, STB, "R1 R2 pulled-up pins give Standby");

    // R5 R7: sweep from Standby
    for (int c = 0; c < 8; c++) begin
      pins(1, 1, 1); tick(4);
      pins(c[2], c[1], c[0]); tick(4);
      chk(mode, drv, rsel, c[2] ? STB : ((c[1] && c[0]) ? NRM : SIL), "R5 R7 from Standby");
    end

    // R6 R4: sweep from Normal
    for (int c = 0; c < 8; c++) begin
      pins(1, 1, 1); tick(4);
      pins(0, 1, 1); tick(4);
      pins(c[2], c[1], c[0]); tick(4);
      chk(mode, drv, rsel, c[2] ? STB : (c[1] ? NRM : SIL), "R6 R4 from Normal");
    end

    // R3: undervoltage sweep, then recovery
    for (int c = 0; c < 8; c++) begin
      pins(0, 1, 1); tick(4);
      vcc_uv = c[0]; vio_uv = !c[0];
      pins(c[2], c[1], c[0]); tick(4);
      chk(mode, drv, rsel, UNP, "R3 undervoltage forces Unpowered");
      vcc_uv = 0; vio_uv = 0; tick(2);
      chk(mode, drv, rsel, c[2] ? STB : ((c[1] && c[0]) ? NRM : SIL), "R3 R5 recovery");
    end

    // R12: latency of three clocks
    pins(1, 1, 1); tick(4);
    pins(0, 1, 1); tick(2);
    chk(mode, drv, rsel, STB, "R12 no change after two clocks");
    tick(1);
    chk(mode, drv, rsel, NRM, "R12 change after three clocks");

    // R11: variant without silent pin
    pins(0, 0, 1); tick(4);
    chk(mode, drv, rsel, SIL, "R11 main instance honours silent pin");
    chk(mode2, drv2, rsel2, NRM, "R11 variant ignores silent pin");
    pins(0, 1, 1); tick(4);

    // R8: short clamp run has no effect
    hsc = 1; tick(DEB - 1); hsc = 0; tick(4);
    chk(mode, drv, rsel, NRM, "R8 short clamp run ignored");
    // R8: full clamp run
    hsc = 1; tick(DEB + 2);
    chk(mode, drv, rsel, SIL, "R8 clamp forces Silent");
    hsc = 0; tick(6);
    chk(mode, drv, rsel, SIL, "R8 R9 error latched keeps Silent");
    // R9: RXD low clears
    rxd = 0; tick(3); rxd = 1; tick(4);
    chk(mode, drv, rsel, NRM, "R9 RXD low clears error");
    // R9: Standby clears
    hsc = 1; tick(DEB + 2); hsc = 0; tick(2);
    chk(mode, drv, rsel, SIL, "R8 clamp again");
    pins(1, 1, 1); tick(4);
    chk(mode, drv, rsel, STB, "R4 Standby during error");
    pins(0, 1, 1); tick(4);
    chk(mode, drv, rsel, NRM, "R9 Standby cleared error");
    // R10: driver permit off in Silent while TXD low
    pins(0, 0, 0); tick(4);
    chk(mode, drv, rsel, SIL, "R10 no driver in Silent");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule